// File: doc/BRIEF.md
# Keyed Single-Shot Register Write Guard

This block sits between a simple address/data/write-strobe bus and a group of configuration registers. It keeps those registers safe from stray writes. A set of word addresses, starting at a base address, is marked as protected. Writes to those addresses are honoured only after software has written a fixed 16-bit key to a dedicated key address. That key opens a window for exactly one protected write. The protected write takes effect and closes the window in the same step, so no separate relock access is needed.

Writes to any other address always pass through on a separate strobe. They neither need the key nor use up an open window. If a protected write arrives while the window is closed, it is dropped and a sticky violation flag is raised. Two protected registers are included as an example: a 4-bit interface-configuration register with named mode bits, and a full-width timing register. Each one needs its own fresh key before it can be changed.

Top module: `keyed_wr_guard`

## Requirements
- R1: After reset the window is closed, the violation flag is 0, and both example registers read 0.
- R2: A write to the key address (default 0x44) whose data bits [15:0] equal 0xA25E opens the window from the next cycle. Data bits above bit 15 are ignored. A repeated key write leaves the window open.
- R3: A write to the key address whose low 16 bits differ from 0xA25E leaves the window closed, or closes it if it was open.
- R4: A protected write (default addresses 0x30 and 0x34) while the window is open raises that register's strobe in the same cycle. The register takes the data at the clock edge, and the window is closed from the next cycle.
- R5: A protected write while the window is closed raises no strobe and leaves the register unchanged. The violation flag is 1 from the next cycle.
- R6: One key opens one write only. A second protected write after a single key write is dropped, even if it targets a different protected register.
- R7: A write to any address that is neither the key address nor protected raises the free strobe in the same cycle, whether the window is open or closed. It leaves the window state as it was.
- R8: The interface-configuration register (address 0x30) takes data bits [3:0]. Bit 3 is write-protect, bit 2 is large-block, bit 1 is long (5-byte) addressing and bit 0 is 16-bit bus. Each bit appears on its own output. The timing register (address 0x34) takes all 32 data bits.
- R9: At most one protected strobe is high in any cycle, and only while the window is open.
- R10: Once set, the violation flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 32 | Bus write data |
| prot_we | output | 2 | Per-register strobe for protected writes that are accepted |
| free_we | output | 1 | Strobe for writes to unguarded addresses |
| win_open | output | 1 | Window open: the next protected write will be honoured |
| violation | output | 1 | Sticky flag for a protected write that was dropped |
| cfg_wp | output | 1 | Config bit 3, write-protect |
| cfg_large_blk | output | 1 | Config bit 2, large-block |
| cfg_long_addr | output | 1 | Config bit 1, 5-byte addressing |
| cfg_wide_bus | output | 1 | Config bit 0, 16-bit bus |
| tim_q | output | 32 | Timing register contents |

## Verification
On every cycle, the bound checker confirms the following. The protected strobes are one-hot or idle and appear only inside an open window. Every accepted protected write closes the window. A key write opens it and a wrong value closes it. A free write never disturbs it. A dropped protected write raises the violation flag, and the flag never falls.

Some properties can only be shown by the bench scenarios: the stored register contents, the mapping of configuration bits to outputs, the masking of upper key bits, and the rule that one key buys exactly one write across both registers. The bench shows these with a driver that predicts the state after each access and a monitor that compares it.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

  localparam logic [15:0] UNLOCK_KEY = 16'hA25E;

  // Field positions of the interface-configuration register
  localparam int CFG_WIDE_BUS_BIT  = 0;
  localparam int CFG_LONG_ADDR_BIT = 1;
  localparam int CFG_LARGE_BLK_BIT = 2;
  localparam int CFG_WP_BIT        = 3;
  localparam int CFG_W             = 4;

  function automatic logic key_match(input logic [15:0] v);
    return v == UNLOCK_KEY;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_take(input logic [CFG_W-1:0] d);
    return d;
  endfunction

endpackage

// File: rtl/kl_addr_decode.sv
module kl_addr_decode #(
  parameter int ADDR_W    = 8,
  parameter int LOCK_ADDR = 'h44,
  parameter int PROT_BASE = 'h30,
  parameter int NPROT     = 2,
  parameter int STRIDE    = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              lock_sel,
  output logic [NPROT-1:0]  prot_sel,
  output logic              free_sel
);

  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

  assign lock_sel = wr_en && (wr_addr == LOCK_A);

  for (genvar i = 0; i < NPROT; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(PROT_BASE + STRIDE * i);
    assign prot_sel[i] = wr_en && (wr_addr == SLOT_A);
  end

  assign free_sel = wr_en && !lock_sel && !(|prot_sel);

endmodule

// File: rtl/kl_window.sv
module kl_window (
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr,
  input  logic bad_key_wr,
  input  logic prot_try,
  output logic win_open,
  output logic violation
);

  logic open_q, viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      if (key_wr)
        open_q <= 1'b1;
      else if (bad_key_wr)
        open_q <= 1'b0;
      else if (prot_try && open_q)
        open_q <= 1'b0;
      if (prot_try && !open_q)
        viol_q <= 1'b1;
    end
  end

  assign win_open  = open_q;
  assign violation = viol_q;

endmodule

// File: rtl/kl_example_regs.sv
module kl_example_regs
  import keylock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              tim_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [DATA_W-1:0] tim_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tim_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_take(wr_data[CFG_W-1:0]);
      if (tim_we) tim_q <= wr_data;
    end
  end

endmodule

// File: rtl/keyed_wr_guard.sv
module keyed_wr_guard
  import keylock_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LOCK_ADDR = 'h44,
  parameter int PROT_BASE = 'h30,
  parameter int NPROT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NPROT-1:0]  prot_we,
  output logic              free_we,
  output logic              win_open,
  output logic              violation,
  output logic              cfg_wp,
  output logic              cfg_large_blk,
  output logic              cfg_long_addr,
  output logic              cfg_wide_bus,
  output logic [DATA_W-1:0] tim_q
);

  localparam int CFG_SLOT = 0;
  localparam int TIM_SLOT = 1;

  // Named internal events, also observed by the checker
  logic             lock_sel;
  logic [NPROT-1:0] prot_sel;
  logic             free_sel;
  logic             key_ok;
  logic             prot_any;
  logic [CFG_W-1:0] cfg_q;

  kl_addr_decode #(
    .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .PROT_BASE(PROT_BASE),
    .NPROT(NPROT), .STRIDE(4)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr),
    .lock_sel(lock_sel), .prot_sel(prot_sel), .free_sel(free_sel)
  );

  assign key_ok   = key_match(wr_data[15:0]);
  assign prot_any = |prot_sel;

  kl_window u_win (
    .clk(clk), .rst_n(rst_n),
    .key_wr(lock_sel && key_ok),
    .bad_key_wr(lock_sel && !key_ok),
    .prot_try(prot_any),
    .win_open(win_open), .violation(violation)
  );

  assign prot_we = prot_sel & {NPROT{win_open}};
  assign free_we = free_sel;

  kl_example_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(prot_we[CFG_SLOT]), .tim_we(prot_we[TIM_SLOT]),
    .wr_data(wr_data), .cfg_q(cfg_q), .tim_q(tim_q)
  );

  assign cfg_wp        = cfg_q[CFG_WP_BIT];
  assign cfg_large_blk = cfg_q[CFG_LARGE_BLK_BIT];
  assign cfg_long_addr = cfg_q[CFG_LONG_ADDR_BIT];
  assign cfg_wide_bus  = cfg_q[CFG_WIDE_BUS_BIT];

endmodule

// File: rtl/kl_checker.sv
module kl_checker #(
  parameter int NPROT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_sel,
  input logic             key_ok,
  input logic             prot_any,
  input logic             free_sel,
  input logic [NPROT-1:0] prot_we,
  input logic             win_open,
  input logic             violation
);

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prot_we));

  p_we_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|prot_we) |-> win_open);

  p_close_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|prot_we) |=> !win_open);

  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_sel && key_ok) |=> win_open);

  p_bad_key_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_sel && !key_ok) |=> !win_open);

  p_drop_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_any && !win_open) |=> violation);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  p_free_keeps_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (free_sel && win_open) |=> win_open);

endmodule

bind keyed_wr_guard kl_checker #(.NPROT(NPROT)) u_kl_checker (
  .clk(clk), .rst_n(rst_n), .lock_sel(lock_sel), .key_ok(key_ok),
  .prot_any(prot_any), .free_sel(free_sel), .prot_we(prot_we),
  .win_open(win_open), .violation(violation)
);

// File: tb/test_keyed_wr_guard.sv
`timescale 1ns/1ps
module test_keyed_wr_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  prot_we;
  logic        free_we, win_open, violation;
  logic        cfg_wp, cfg_large_blk, cfg_long_addr, cfg_wide_bus;
  logic [31:0] tim_q;

  always #10 clk = ~clk;

  keyed_wr_guard i_keyed_wr_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prot_we(prot_we), .free_we(free_we),
    .win_open(win_open), .violation(violation), .cfg_wp(cfg_wp),
    .cfg_large_blk(cfg_large_blk), .cfg_long_addr(cfg_long_addr),
    .cfg_wide_bus(cfg_wide_bus), .tim_q(tim_q)
  );

  localparam logic [7:0] A_KEY = 8'h44, A_CFG = 8'h30, A_TIM = 8'h34;

  typedef struct {
    string       tag;
    logic [1:0]  pwe;
    logic        fwe;
    logic        open;
    logic        viol;
    logic [3:0]  cfg;
    logic [31:0] tim;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // bench-side model, built from the requirements
  logic        m_open = 0, m_viol = 0;
  logic [3:0]  m_cfg = 0;
  logic [31:0] m_tim = 0;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    it.tag = tag; it.pwe = 2'b00; it.fwe = 1'b0;
    if (a == A_KEY) begin
      m_open = (d[15:0] == 16'hA25E);
    end else if (a == A_CFG || a == A_TIM) begin
      if (m_open) begin
        if (a == A_CFG) begin it.pwe = 2'b01; m_cfg = d[3:0]; end
        else begin it.pwe = 2'b10; m_tim = d; end
        m_open = 1'b0;
      end else begin
        m_viol = 1'b1;
      end
    end else begin
      it.fwe = 1'b1;
    end
    it.open = m_open; it.viol = m_viol; it.cfg = m_cfg; it.tim = m_tim;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  // monitor: strobes mid-cycle, state after the edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(prot_we == it.pwe, {it.tag, " prot_we R9"}, 32'(prot_we), 32'(it.pwe));
        check(free_we == it.fwe, {it.tag, " free_we R7"}, 32'(free_we), 32'(it.fwe));
        @(posedge clk);
        #2;
        check(win_open == it.open, {it.tag, " win_open"}, 32'(win_open), 32'(it.open));
        check(violation == it.viol, {it.tag, " violation R10"}, 32'(violation), 32'(it.viol));
        check({cfg_wp, cfg_large_blk, cfg_long_addr, cfg_wide_bus} == it.cfg,
              {it.tag, " cfg bits R8"},
              32'({cfg_wp, cfg_large_blk, cfg_long_addr, cfg_wide_bus}), 32'(it.cfg));
        check(tim_q == it.tim, {it.tag, " tim_q"}, tim_q, it.tim);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    check(win_open == 1'b0, "R1 reset window", 32'(win_open), 0);
    check(violation == 1'b0, "R1 reset violation", 32'(violation), 0);
    check({cfg_wp, cfg_large_blk, cfg_long_addr, cfg_wide_bus} == 4'h0, "R1 reset cfg",
          32'({cfg_wp, cfg_large_blk, cfg_long_addr, cfg_wide_bus}), 0);
    check(tim_q == 32'h0, "R1 reset tim", tim_q, 0);

    bus_write(A_KEY, 32'h0000_0000, "R1 R3 wrong key from reset");
    bus_write(8'h10, 32'hDEAD_BEEF, "R7 free write while locked");
    bus_write(A_CFG, 32'h0000_000F, "R5 cfg write while locked");
    bus_write(A_KEY, 32'hFFFF_A25E, "R2 key with junk upper bits");
    bus_write(8'h48, 32'h1234_5678, "R7 free write in window");
    bus_write(8'h00, 32'h0, "R7 second free write in window");
    bus_write(A_CFG, 32'hFFFF_FFF6, "R4 R8 cfg large+long");
    bus_write(A_TIM, 32'h0123_4567, "R6 tim after used key");
    bus_write(A_KEY, 32'h0000_A25E, "R2 key");
    bus_write(A_TIM, 32'h05A5_A5A5, "R4 R8 tim full width");
    bus_write(A_CFG, 32'h0000_0001, "R6 cfg without fresh key");
    idle(2);
    bus_write(A_KEY, 32'h0000_A25E, "R2 key before relock");
    bus_write(A_KEY, 32'h0001_A25F, "R3 bad key relocks");
    bus_write(A_CFG, 32'h0000_0009, "R3 R5 cfg after relock");
    bus_write(A_KEY, 32'h0000_A25E, "R2 key");
    bus_write(A_KEY, 32'h8000_A25E, "R2 repeated key");
    idle(3);
    bus_write(A_CFG, 32'h0000_0009, "R4 R8 cfg wp+wide after idle");
    bus_write(A_KEY, 32'h0000_A25E, "R2 key for tim");
    bus_write(A_TIM, 32'hFFFF_FFFF, "R4 tim all ones");
    bus_write(A_TIM, 32'h0, "R6 R10 tim dropped");
    idle(3);
    done = 1;
    report();
  end

endmodule